// File: doc/BRIEF.md
# Two-Cycle Register Bus Slave

This block is the bus-facing front end of a bank of 16-bit control and status registers. A Wishbone master reaches it with cyc, stb, we, a word address, a 16-bit write data bus and two byte selects. The block answers with read data, an ack and an error flag. Towards the register file it gives a one-hot register select, per-byte write strobes and the write data. The register contents stay outside the block and come back in on a flat read bus.

With the default wait-state setting, each access takes two cycles. In the first cycle the block captures only the address. In the second cycle it decodes that captured address, drives read data and acks. Write data is not registered: the register file samples it in the second cycle, so the write data bus may settle over two cycles while the address must be valid in one. Read data is never latched. If the master drops cyc or stb before the second cycle, the block raises a one-cycle error in place of the ack. A parameter switches to zero-wait operation, in which the block decodes the live address and acks in the same cycle.

Top module: `regbank_wb_slave`

## Requirements
- R1: While rst_n is low in wait-state mode, ack_o, err_o, reg_sel_o, reg_wstrb_o and dat_o are all zero, even with cyc_i and stb_i high. After reset the slave is idle.
- R2: In wait-state mode, the first cycle with cyc_i and stb_i both high gives no ack. The ack comes in the next cycle if cyc_i and stb_i are still both high.
- R3: In the ack cycle of wait-state mode, decode and read data use the address captured in the first cycle, whatever adr_i carries then.
- R4: reg_wdata_o always equals dat_i. Write strobes appear only in an ack cycle with we_i high, so the register file samples write data in that cycle.
- R5: On an acked write to a mapped address, reg_wstrb_o equals sel_i. Bit 0 enables data bits 7:0 and bit 1 enables bits 15:8.
- R6: In an acked read of a mapped address, dat_o equals that register's slice of reg_rdata_i (register n at bits 16n+15:16n). In every other cycle dat_o is zero.
- R7: Addresses at or above NUM_REGS are unmapped. A read of one acks with dat_o zero. A write to one acks but raises no select and no strobe.
- R8: In wait-state mode, if cyc_i or stb_i is low in the second cycle, err_o is high for that one cycle, no ack is given, and the slave returns to idle. ack_o and err_o are never high together.
- R9: In wait-state mode, ack_o is a one-cycle pulse. A request held high in the cycle after an ack counts as the first cycle of a new transfer.
- R10: With WAIT_MODE set to 0, ack_o equals cyc_i and stb_i in the same cycle, decode uses the live adr_i, and err_o stays low.
- R11: reg_sel_o is one-hot on the addressed register during an ack to a mapped address, and all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Strobe for this transfer |
| we_i | input | 1 | High for write, low for read |
| adr_i | input | ADDR_W | Word address |
| dat_i | input | 16 | Write data |
| sel_i | input | 2 | Byte lane selects |
| reg_rdata_i | input | NUM_REGS*16 | Flat read bus from the register file, register n at bits 16n+15:16n |
| dat_o | output | 16 | Read data, zero outside an acked read |
| ack_o | output | 1 | Transfer acknowledge |
| err_o | output | 1 | Transfer abandoned before its second cycle |
| reg_sel_o | output | NUM_REGS | One-hot register select during ack |
| reg_wstrb_o | output | 2 | Byte lane write strobes |
| reg_wdata_o | output | 16 | Write data passed to the register file |

## Verification
The assertions take it that a request seen in the first cycle is an honest start of a transfer. They take it that the register file returns data only through reg_rdata_i and never through a path back to the address. They make no assumption about when the master lowers stb, because abandonment is a legal event that the error path must cover. The stimulus covers this in several ways. It holds requests across the two cycles. It drops cyc_i or stb_i in the second cycle on purpose. It changes adr_i between the two cycles, and it keeps requests high back to back across acks. A random phase mixes all of these with unmapped addresses and every byte select value.

// File: rtl/regbank_wb_pkg.sv
package regbank_wb_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // true when a word address falls inside the implemented register range
  function automatic logic addr_mapped(input logic [31:0] adr, input int unsigned nregs);
    return adr < nregs;
  endfunction

endpackage

// File: rtl/wbr_phase.sv
module wbr_phase
  import regbank_wb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] adr_i,
  output logic              acc_ok,
  output logic              acc_err,
  output logic [ADDR_W-1:0] dec_adr
);

  phase_e            st_q;
  logic [ADDR_W-1:0] adr_q;
  logic              start_evt;

  assign start_evt = (st_q == PH_IDLE) && req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      adr_q <= '0;
    end else begin
      case (st_q)
        PH_IDLE: if (req) st_q <= PH_DATA;
        default: st_q <= PH_IDLE;
      endcase
      // only the address is captured; data passes straight through
      if (start_evt) adr_q <= adr_i;
    end
  end

  assign acc_ok  = (st_q == PH_DATA) && req;
  assign acc_err = (st_q == PH_DATA) && !req;
  assign dec_adr = adr_q;

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> !acc_ok);
  assert_err_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> (!acc_ok && !acc_err));
  assert_ack_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> $past(req));
  assert_err_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(start_evt));

endmodule

// File: rtl/wbr_decode.sv
module wbr_decode
  import regbank_wb_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 24,
  parameter int NLANE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] adr,
  input  logic              hit_en,
  input  logic              we,
  input  logic [NLANE-1:0]  sel,
  output logic [NUM_REGS-1:0] sel_oh,
  output logic [NLANE-1:0]  wstrb,
  output logic              rd_en
);

  logic mapped;

  assign mapped = addr_mapped(32'(adr), NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_oh[g] = hit_en && mapped && (adr == ADDR_W'(g));
  end

  assign wstrb = (hit_en && we && mapped) ? sel : '0;
  assign rd_en = hit_en && !we && mapped;

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));
  assert_sel_needs_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_oh) |-> hit_en);
  assert_strobe_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|wstrb) |-> (hit_en && we && (|sel_oh)));
  assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (sel_oh == '0 && wstrb == '0 && !rd_en));

endmodule

// File: rtl/wbr_rdmux.sv
module wbr_rdmux #(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REGS-1:0]        sel_oh,
  input  logic                       rd_en,
  input  logic [NUM_REGS*DATA_W-1:0] rdata_flat,
  output logic [DATA_W-1:0]          dat
);

  logic [DATA_W-1:0] or_tree;

  // AND-OR mux over the one-hot select; nothing is latched
  always_comb begin
    or_tree = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_oh[i]) or_tree = or_tree | rdata_flat[i*DATA_W +: DATA_W];
    end
  end

  assign dat = rd_en ? or_tree : '0;

  assert_rdata_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|dat) |-> (rd_en && (|sel_oh)));

endmodule

// File: rtl/regbank_wb_slave.sv
module regbank_wb_slave #(
  parameter int ADDR_W    = 5,
  parameter int NUM_REGS  = 24,
  parameter int WAIT_MODE = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_i,
  input  logic                   stb_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      adr_i,
  input  logic [15:0]            dat_i,
  input  logic [1:0]             sel_i,
  input  logic [NUM_REGS*16-1:0] reg_rdata_i,
  output logic [15:0]            dat_o,
  output logic                   ack_o,
  output logic                   err_o,
  output logic [NUM_REGS-1:0]    reg_sel_o,
  output logic [1:0]             reg_wstrb_o,
  output logic [15:0]            reg_wdata_o
);

  localparam int DATA_W = 16;
  localparam int NLANE  = DATA_W / 8;

  logic              req;
  logic              acc_ok;
  logic              acc_err;
  logic [ADDR_W-1:0] dec_adr;
  logic              rd_en;

  assign req = cyc_i && stb_i;

  if (WAIT_MODE != 0) begin : g_wait
    wbr_phase #(.ADDR_W(ADDR_W)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .adr_i   (adr_i),
      .acc_ok  (acc_ok),
      .acc_err (acc_err),
      .dec_adr (dec_adr)
    );
  end else begin : g_zero
    assign acc_ok  = req;
    assign acc_err = 1'b0;
    assign dec_adr = adr_i;
  end

  wbr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .NLANE    (NLANE)
  ) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .adr    (dec_adr),
    .hit_en (acc_ok),
    .we     (we_i),
    .sel    (sel_i),
    .sel_oh (reg_sel_o),
    .wstrb  (reg_wstrb_o),
    .rd_en  (rd_en)
  );

  wbr_rdmux #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rdmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_oh     (reg_sel_o),
    .rd_en      (rd_en),
    .rdata_flat (reg_rdata_i),
    .dat        (dat_o)
  );

  assign ack_o       = acc_ok;
  assign err_o       = acc_err;
  assign reg_wdata_o = dat_i;

  assert_ack_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && err_o));
  assert_err_needs_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !(cyc_i && stb_i));
  assert_strobe_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wstrb_o) |-> (ack_o && we_i));

endmodule

// File: tb/regbank_wb_slave_tb_top.sv
module regbank_wb_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 5;
  localparam int NREG = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [15:0]   dat = '0;
  logic [1:0]    sel = '0;

  logic [15:0] regs_w [NREG];
  logic [15:0] regs_z [NREG];
  logic [NREG*16-1:0] rd_w, rd_z;

  logic [15:0] w_dat, z_dat, w_wd, z_wd;
  logic w_ack, w_err, z_ack, z_err;
  logic [NREG-1:0] w_sel, z_sel;
  logic [1:0] w_wst, z_wst;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // model state of the wait-state slave
  int ph = 0;
  logic [AW-1:0] cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      rd_w[i*16 +: 16] = regs_w[i];
      rd_z[i*16 +: 16] = regs_z[i];
    end
  end

  regbank_wb_slave #(.ADDR_W(AW), .NUM_REGS(NREG), .WAIT_MODE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(dat), .sel_i(sel), .reg_rdata_i(rd_w), .dat_o(w_dat), .ack_o(w_ack),
    .err_o(w_err), .reg_sel_o(w_sel), .reg_wstrb_o(w_wst), .reg_wdata_o(w_wd));

  regbank_wb_slave #(.ADDR_W(AW), .NUM_REGS(NREG), .WAIT_MODE(0)) dut_zw_i (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(dat), .sel_i(sel), .reg_rdata_i(rd_z), .dat_o(z_dat), .ack_o(z_ack),
    .err_o(z_err), .reg_sel_o(z_sel), .reg_wstrb_o(z_wst), .reg_wdata_o(z_wd));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] s);
    logic [15:0] m;
    m = {{8{s[1]}}, {8{s[0]}}};
    return (old & ~m) | (nw & m);
  endfunction

  // one bus cycle: drive, compare both DUTs against the model, advance the model
  task automatic cycle(input logic c, input logic s, input logic w, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic [1:0] sl);
    logic r;
    logic ea, ee;
    logic [NREG-1:0] es;
    logic [1:0] ew;
    logic [15:0] ed;
    @(negedge clk);
    cyc = c; stb = s; we = w; adr = a; dat = d; sel = sl;
    #1;
    r = c && s;
    // wait-state reference
    ea = 0; ee = 0; es = '0; ew = '0; ed = '0;
    if (ph == 1) begin
      if (r) begin
        ea = 1;
        if (int'(cap) < NREG) begin
          es[cap] = 1'b1;
          if (w) ew = sl; else ed = regs_w[cap];
        end
      end else ee = 1;
    end
    chk("R2 R9", "wait ack", 32'(w_ack), 32'(ea));
    chk("R8", "wait err", 32'(w_err), 32'(ee));
    chk("R11 R7 R3", "wait sel", 32'(w_sel), 32'(es));
    chk("R5 R4", "wait wstrb", 32'(w_wst), 32'(ew));
    chk("R6 R7 R3", "wait rdata", 32'(w_dat), 32'(ed));
    chk("R4", "wait wdata", 32'(w_wd), 32'(d));
    // zero-wait reference
    begin
      logic [NREG-1:0] zs;
      logic [1:0] zw;
      logic [15:0] zd;
      zs = '0; zw = '0; zd = '0;
      if (r && int'(a) < NREG) begin
        zs[a] = 1'b1;
        if (w) zw = sl; else zd = regs_z[a];
      end
      chk("R10", "zero ack", 32'(z_ack), 32'(r));
      chk("R10", "zero err", 32'(z_err), 32'd0);
      chk("R10 R11", "zero sel", 32'(z_sel), 32'(zs));
      chk("R10 R5", "zero wstrb", 32'(z_wst), 32'(zw));
      chk("R10 R6", "zero rdata", 32'(z_dat), 32'(zd));
      @(posedge clk);
      if (r && w && int'(a) < NREG) regs_z[a] = merge(regs_z[a], d, sl);
    end
    if (ea && w && int'(cap) < NREG) regs_w[cap] = merge(regs_w[cap], d, sl);
    if (ph == 0 && r) begin ph = 1; cap = a; end
    else ph = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      regs_w[i] = 16'hA000 + 16'(i * 17);
      regs_z[i] = 16'hA000 + 16'(i * 17);
    end
    // R1: reset with a request present
    cyc = 1; stb = 1; we = 1; adr = 5'd3; sel = 2'b11; dat = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "reset ack", 32'(w_ack), 0);
    chk("R1", "reset err", 32'(w_err), 0);
    chk("R1", "reset sel", 32'(w_sel), 0);
    chk("R1", "reset wstrb", 32'(w_wst), 0);
    chk("R1", "reset rdata", 32'(w_dat), 0);
    cyc = 0; stb = 0;
    @(posedge clk);
    @(negedge clk); rst_n = 1;
    cycle(0, 0, 0, 0, 0, 0);
    // R2 R6: plain read
    cycle(1, 1, 0, 5'd3, 0, 0);
    cycle(1, 1, 0, 5'd3, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    // R3: address moves in the ack cycle
    cycle(1, 1, 1, 5'd5, 16'h1234, 2'b11);
    cycle(1, 1, 1, 5'd7, 16'h5678, 2'b11);
    cycle(1, 1, 0, 5'd9, 0, 0);
    cycle(1, 1, 0, 5'd5, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    // R5: each byte lane select value, read back after each
    for (int k = 0; k < 4; k++) begin
      cycle(1, 1, 1, 5'd2, 16'hC3C3 ^ 16'(k * 16'h1111), 2'(k));
      cycle(1, 1, 1, 5'd2, 16'hC3C3 ^ 16'(k * 16'h1111), 2'(k));
      cycle(1, 1, 0, 5'd2, 0, 0);
      cycle(1, 1, 0, 5'd2, 0, 0);
    end
    // R7: unmapped read and write, then confirm mapped neighbour untouched
    cycle(1, 1, 0, 5'd30, 0, 0);
    cycle(1, 1, 0, 5'd30, 0, 0);
    cycle(1, 1, 1, 5'd24, 16'hDEAD, 2'b11);
    cycle(1, 1, 1, 5'd24, 16'hDEAD, 2'b11);
    cycle(1, 1, 0, 5'd23, 0, 0);
    cycle(1, 1, 0, 5'd23, 0, 0);
    // R8: abandon by stb, then by cyc, then resume
    cycle(1, 1, 1, 5'd4, 16'hBEEF, 2'b11);
    cycle(1, 0, 1, 5'd4, 16'hBEEF, 2'b11);
    cycle(1, 1, 0, 5'd4, 0, 0);
    cycle(0, 1, 0, 5'd4, 0, 0);
    cycle(1, 1, 0, 5'd4, 0, 0);
    cycle(1, 1, 0, 5'd4, 0, 0);
    // R9: request held continuously across acks
    for (int k = 0; k < 8; k++) cycle(1, 1, k[0], 5'(k + 10), 16'(k * 16'h0101), 2'b11);
    cycle(0, 0, 0, 0, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      logic c, s;
      c = ($urandom_range(0, 9) != 0);
      s = ($urandom_range(0, 7) != 0);
      cycle(c, s, 1'($urandom), 5'($urandom_range(0, 31)), 16'($urandom), 2'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule